// File: doc/BRIEF.md
# External bus cycle sequencer

This block produces the control strobes for one external memory access of a small controller. Three kinds of access are supported: instruction fetch, data read and data write. Each may run with or without an address-latch pulse. The block runs from a clock at twice the bus rate, so every phase length is counted in half bus clocks.

A request carries the access kind, the address, the write data and an address-latch flag. The block accepts it when it is idle. It also accepts a request in the last half clock of a fetch strobe, provided the request is another fetch without an address-latch pulse. In that case the fetch strobe stays asserted across the boundary.

The block drives the address-latch pulse, one of three strobes, and enables for the address and data pins. A wait input stretches the strobe. The block returns a one-cycle completion pulse and, for reads and fetches, the data it captured.

The timing fields are taken from configuration inputs when the request is accepted:
- the latch-pulse width select;
- the total length of a cycle that has a latch pulse;
- the strobe length of a cycle that has no latch pulse;
- the number of half clocks the write data is held after the write strobe.

Top module: `xbus_cycle_seq`

## Requirements
- R1: In a cycle with a latch pulse, `aleOut` goes high in the first half clock after acceptance. It stays high for 1 half clock when `cfgAleWide` is 0 and for 3 half clocks when it is 1. `aleOut` never rises in a cycle without a latch pulse.
- R2: In a cycle without a latch pulse, the strobe lasts 2·(`cfgStrobeCode`+1) half clocks. That is 2, 4, 6 or 8 half clocks for codes 0 to 3.
- R3: In a cycle with a latch pulse, the strobe starts exactly one half clock after `aleOut` falls and never overlaps it. Its length is the total 2·(`cfgAleTotal`+2) half clocks minus the latch width minus one. The result is raised to one half clock if it would be zero.
- R4: `reqKind` selects the strobe. Code 0 drives `psenOut`, code 1 drives `rdOut`, code 2 drives `wrOut` and code 3 drives `rdOut`. At most one strobe is high at any time.
- R5: `waitIn` is sampled at each edge while a strobe is high. While it is 1 in the strobe's last half clock, the strobe is held. The strobe ends only at an edge where `waitIn` is 0.
- R6: In a write, `dataOe` is high with `dataOut` equal to the request's write data from the start of the cycle. So it leads `wrOut` by the latch width plus one half clock, or by one half clock when there is no latch pulse. It stays high for `cfgWrHold` half clocks after `wrOut` falls.
- R7: For a read or fetch, `readData` shows the `dataIn` value present at the edge where the strobe ends. It holds that value while `doneOut` is high.
- R8: Each accepted request produces exactly one `doneOut` pulse of one cycle. The pulse appears in the cycle after the strobe ends, or after the write hold ends when there is a hold.
- R9: `reqReady` is 1 whenever the block is idle. During a cycle it is 0, except in the last half clock of a fetch strobe that `waitIn` does not hold, while the request on the port is a fetch without a latch pulse.
- R10: A fetch accepted in that slot continues the current fetch without a gap. `psenOut` stays high for the sum of both strobe lengths, and each fetch still gets its own `doneOut` and `readData`.
- R11: `addrOe` is high and `addrOut` holds the request address, unchanged, from acceptance to the end of the cycle. `addrOe` is 0 when the block is idle.
- R12: While `rstN` is low, every strobe, `aleOut`, `addrOe`, `dataOe` and `doneOut` are 0 and `reqReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Double-rate clock; one period is half a bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted at this edge when `reqValid` is 1 |
| reqKind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| reqUseAle | input | 1 | Run the cycle with an address-latch pulse |
| reqAddr | input | ADDR_W | Request address |
| reqWrData | input | DATA_W | Write data |
| cfgAleWide | input | 1 | Latch pulse 3 half clocks when 1, else 1 |
| cfgAleTotal | input | 2 | Total cycle length code for cycles with a latch pulse |
| cfgStrobeCode | input | 2 | Strobe length code for cycles without a latch pulse |
| cfgWrHold | input | HOLD_W | Write data hold after the write strobe, in half clocks |
| waitIn | input | 1 | Strobe extension request |
| dataIn | input | DATA_W | Read data from the bus |
| aleOut | output | 1 | Address-latch pulse |
| psenOut | output | 1 | Fetch strobe, active high |
| rdOut | output | 1 | Read strobe, active high |
| wrOut | output | 1 | Write strobe, active high |
| addrOut | output | ADDR_W | Address to the pins |
| addrOe | output | 1 | Address output enable |
| dataOut | output | DATA_W | Write data to the pins |
| dataOe | output | 1 | Data output enable |
| doneOut | output | 1 | One-cycle completion pulse |
| readData | output | DATA_W | Captured read data |

## Verification
The bench uses the default parameters. These are 16-bit address and data and a 3-bit hold field, so write holds of 0, 3 and 7 half clocks are all within reach. Every latch-width, total-length and strobe-length code can be driven. The corner where a wide latch pulse meets the shortest total is included; it would give a zero strobe, so it checks the one-half-clock floor. A chain of three back-to-back fetches with different lengths exercises the burst slot. A read held by `waitIn` past its programmed end exercises the strobe extension.

// File: rtl/xbus_seq_pkg.sv
package xbus_seq_pkg;

  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_READ  = 2'd1;
  localparam logic [1:0] KIND_WRITE = 2'd2;
  localparam logic [1:0] KIND_READ2 = 2'd3;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ALE    = 3'd1,
    PH_SETUP  = 3'd2,
    PH_STROBE = 3'd3,
    PH_HOLD   = 3'd4
  } phase_e;

  // Strobes from the controller to the datapath.
  typedef struct packed {
    phase_e     phase;
    logic [1:0] kind;
    logic       loadReq;
    logic       capture;
  } seq_ctrl_t;

endpackage

// File: rtl/xbus_seq_timing.sv
module xbus_seq_timing #(
  parameter int LEN_W = 4
) (
  input  logic             useAle,
  input  logic             aleWide,
  input  logic [1:0]       aleTotal,
  input  logic [1:0]       strobeCode,
  output logic [LEN_W-1:0] aleLen,
  output logic [LEN_W-1:0] strobeLen
);

  logic [LEN_W-1:0] totalLen;
  logic [LEN_W-1:0] aleShare;

  always_comb begin
    aleLen   = aleWide ? LEN_W'(3) : LEN_W'(1);
    totalLen = LEN_W'({aleTotal, 1'b0}) + LEN_W'(4);
    aleShare = totalLen - aleLen - LEN_W'(1);
    if (useAle) begin
      strobeLen = (aleShare == '0) ? LEN_W'(1) : aleShare;
    end else begin
      strobeLen = LEN_W'({strobeCode, 1'b0}) + LEN_W'(2);
    end
  end

endmodule

// File: rtl/xbus_seq_ctrl.sv
module xbus_seq_ctrl
  import xbus_seq_pkg::*;
#(
  parameter int LEN_W  = 4,
  parameter int HOLD_W = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk2x,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic              reqUseAle,
  input  logic [LEN_W-1:0]  aleLen,
  input  logic [LEN_W-1:0]  strobeLen,
  input  logic [HOLD_W-1:0] holdLen,
  input  logic              waitIn,
  output logic              reqReady,
  output logic              doneOut,
  output seq_ctrl_t         ctl
);

  phase_e            phase;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        curKind;
  logic [LEN_W-1:0]  pendStrobe;
  logic [HOLD_W-1:0] pendHold;
  logic              doneQ;

  logic lastHalf;
  logic strobeEnd;
  logic burstSlot;
  logic accept;

  assign lastHalf  = (cnt == CNT_W'(1));
  assign strobeEnd = (phase == PH_STROBE) && lastHalf && !waitIn;
  assign burstSlot = strobeEnd && (curKind == KIND_FETCH);
  assign reqReady  = (phase == PH_IDLE) ||
                     (burstSlot && (reqKind == KIND_FETCH) && !reqUseAle);
  assign accept    = reqValid && reqReady;

  always_ff @(posedge clk2x or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      cnt        <= '0;
      curKind    <= KIND_FETCH;
      pendStrobe <= '0;
      pendHold   <= '0;
      doneQ      <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            curKind    <= reqKind;
            pendStrobe <= strobeLen;
            pendHold   <= holdLen;
            if (reqUseAle) begin
              phase <= PH_ALE;
              cnt   <= CNT_W'(aleLen);
            end else if (reqKind == KIND_WRITE) begin
              phase <= PH_SETUP;
              cnt   <= CNT_W'(1);
            end else begin
              phase <= PH_STROBE;
              cnt   <= CNT_W'(strobeLen);
            end
          end
        end
        PH_ALE: begin
          if (lastHalf) begin
            phase <= PH_SETUP;
            cnt   <= CNT_W'(1);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_SETUP: begin
          phase <= PH_STROBE;
          cnt   <= CNT_W'(pendStrobe);
        end
        PH_STROBE: begin
          if (!lastHalf) begin
            cnt <= cnt - CNT_W'(1);
          end else if (!waitIn) begin
            if (accept) begin
              // burst continuation: strobe stays high
              doneQ      <= 1'b1;
              curKind    <= reqKind;
              pendStrobe <= strobeLen;
              pendHold   <= holdLen;
              cnt        <= CNT_W'(strobeLen);
            end else if ((curKind == KIND_WRITE) && (pendHold != '0)) begin
              phase <= PH_HOLD;
              cnt   <= CNT_W'(pendHold);
            end else begin
              phase <= PH_IDLE;
              doneQ <= 1'b1;
            end
          end
        end
        PH_HOLD: begin
          if (lastHalf) begin
            phase <= PH_IDLE;
            doneQ <= 1'b1;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign doneOut     = doneQ;
  assign ctl.phase   = phase;
  assign ctl.kind    = curKind;
  assign ctl.loadReq = accept;
  assign ctl.capture = strobeEnd && (curKind != KIND_WRITE);

endmodule

// File: rtl/xbus_seq_dp.sv
module xbus_seq_dp
  import xbus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk2x,
  input  logic              rstN,
  input  seq_ctrl_t         ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic [DATA_W-1:0] dataIn,
  output logic              aleOut,
  output logic              psenOut,
  output logic              rdOut,
  output logic              wrOut,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrOe,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic [DATA_W-1:0] readData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wrDataQ;
  logic [DATA_W-1:0] rdDataQ;
  logic              busy;
  logic              strobePh;

  always_ff @(posedge clk2x or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wrDataQ <= '0;
      rdDataQ <= '0;
    end else begin
      if (ctl.loadReq) begin
        addrQ   <= reqAddr;
        wrDataQ <= reqWrData;
      end
      if (ctl.capture) begin
        rdDataQ <= dataIn;
      end
    end
  end

  assign busy     = (ctl.phase != PH_IDLE);
  assign strobePh = (ctl.phase == PH_STROBE);

  assign aleOut   = (ctl.phase == PH_ALE);
  assign psenOut  = strobePh && (ctl.kind == KIND_FETCH);
  assign rdOut    = strobePh && ((ctl.kind == KIND_READ) || (ctl.kind == KIND_READ2));
  assign wrOut    = strobePh && (ctl.kind == KIND_WRITE);
  assign addrOut  = addrQ;
  assign addrOe   = busy;
  assign dataOut  = wrDataQ;
  assign dataOe   = busy && (ctl.kind == KIND_WRITE);
  assign readData = rdDataQ;

endmodule

// File: rtl/xbus_cycle_seq.sv
module xbus_cycle_seq
  import xbus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int HOLD_W = 3
) (
  input  logic              clk2x,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqKind,
  input  logic              reqUseAle,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic              cfgAleWide,
  input  logic [1:0]        cfgAleTotal,
  input  logic [1:0]        cfgStrobeCode,
  input  logic [HOLD_W-1:0] cfgWrHold,
  input  logic              waitIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              aleOut,
  output logic              psenOut,
  output logic              rdOut,
  output logic              wrOut,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrOe,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              doneOut,
  output logic [DATA_W-1:0] readData
);

  localparam int LEN_W = 4;
  localparam int CNT_W = (HOLD_W > LEN_W) ? HOLD_W : LEN_W;

  logic [LEN_W-1:0] aleLen;
  logic [LEN_W-1:0] strobeLen;
  seq_ctrl_t        ctl;

  xbus_seq_timing #(.LEN_W(LEN_W)) u_timing (
    .useAle     (reqUseAle),
    .aleWide    (cfgAleWide),
    .aleTotal   (cfgAleTotal),
    .strobeCode (cfgStrobeCode),
    .aleLen     (aleLen),
    .strobeLen  (strobeLen)
  );

  xbus_seq_ctrl #(.LEN_W(LEN_W), .HOLD_W(HOLD_W), .CNT_W(CNT_W)) u_ctrl (
    .clk2x     (clk2x),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqKind   (reqKind),
    .reqUseAle (reqUseAle),
    .aleLen    (aleLen),
    .strobeLen (strobeLen),
    .holdLen   (cfgWrHold),
    .waitIn    (waitIn),
    .reqReady  (reqReady),
    .doneOut   (doneOut),
    .ctl       (ctl)
  );

  xbus_seq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk2x     (clk2x),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqAddr   (reqAddr),
    .reqWrData (reqWrData),
    .dataIn    (dataIn),
    .aleOut    (aleOut),
    .psenOut   (psenOut),
    .rdOut     (rdOut),
    .wrOut     (wrOut),
    .addrOut   (addrOut),
    .addrOe    (addrOe),
    .dataOut   (dataOut),
    .dataOe    (dataOe),
    .readData  (readData)
  );

endmodule

// File: rtl/xbus_seq_checker.sv
module xbus_seq_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk2x,
  input logic              rstN,
  input logic              reqReady,
  input logic              waitIn,
  input logic              aleOut,
  input logic              psenOut,
  input logic              rdOut,
  input logic              wrOut,
  input logic [ADDR_W-1:0] addrOut,
  input logic              addrOe,
  input logic              dataOe,
  input logic              doneOut
);

  logic anyStrobe;
  assign anyStrobe = psenOut || rdOut || wrOut;

  AST_ONE_STROBE: assert property (@(posedge clk2x) disable iff (!rstN)
    $onehot0({psenOut, rdOut, wrOut})); // R4

  AST_ALE_STROBE_APART: assert property (@(posedge clk2x) disable iff (!rstN)
    !(aleOut && anyStrobe)); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk2x) disable iff (!rstN)
    doneOut |=> !doneOut); // R8

  AST_WRITE_DRIVES_DATA: assert property (@(posedge clk2x) disable iff (!rstN)
    wrOut |-> dataOe); // R6

  AST_ADDR_STEADY: assert property (@(posedge clk2x) disable iff (!rstN)
    (addrOe && $past(addrOe) && !doneOut) |-> $stable(addrOut)); // R11

  AST_WAIT_RELEASE: assert property (@(posedge clk2x) disable iff (!rstN)
    $fell(anyStrobe) |-> !$past(waitIn)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk2x) disable iff (!rstN)
    (reqReady && !anyStrobe) |-> (!aleOut && !addrOe)); // R9

endmodule

bind xbus_cycle_seq xbus_seq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk2x    (clk2x),
  .rstN     (rstN),
  .reqReady (reqReady),
  .waitIn   (waitIn),
  .aleOut   (aleOut),
  .psenOut  (psenOut),
  .rdOut    (rdOut),
  .wrOut    (wrOut),
  .addrOut  (addrOut),
  .addrOe   (addrOe),
  .dataOe   (dataOe),
  .doneOut  (doneOut)
);

// File: tb/xbus_cycle_seq_bench.sv
module xbus_cycle_seq_bench;

  localparam logic [15:0] MEM_KEY = 16'hA5C3;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic        reqReady;
  logic [1:0]  reqKind;
  logic        reqUseAle;
  logic [15:0] reqAddr;
  logic [15:0] reqWrData;
  logic        cfgAleWide;
  logic [1:0]  cfgAleTotal;
  logic [1:0]  cfgStrobeCode;
  logic [2:0]  cfgWrHold;
  logic        waitIn;
  logic [15:0] dataIn;
  logic        aleOut, psenOut, rdOut, wrOut;
  logic [15:0] addrOut;
  logic        addrOe;
  logic [15:0] dataOut;
  logic        dataOe;
  logic        doneOut;
  logic [15:0] readData;

  always #5 clk = ~clk;

  // bus memory model: read data depends only on the address
  assign dataIn = addrOut ^ MEM_KEY;

  xbus_cycle_seq u_xbus_cycle_seq (
    .clk2x(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqUseAle(reqUseAle), .reqAddr(reqAddr),
    .reqWrData(reqWrData), .cfgAleWide(cfgAleWide), .cfgAleTotal(cfgAleTotal),
    .cfgStrobeCode(cfgStrobeCode), .cfgWrHold(cfgWrHold), .waitIn(waitIn),
    .dataIn(dataIn), .aleOut(aleOut), .psenOut(psenOut), .rdOut(rdOut),
    .wrOut(wrOut), .addrOut(addrOut), .addrOe(addrOe), .dataOut(dataOut),
    .dataOe(dataOe), .doneOut(doneOut), .readData(readData)
  );

  typedef struct {
    logic [1:0]  kind;
    logic [15:0] addr;
    logic [15:0] wd;
    int          aleH;
    int          strH;
    int          setupH;
    int          holdH;
    string       tag;
  } item_t;

  item_t expQ[$];
  item_t head;

  int checks = 0;
  int fails = 0;
  int issued = 0;
  int doneCount = 0;
  bit finished = 0;

  int aleCnt = 0, strCnt = 0, setupCnt = 0, holdCnt = 0;
  bit wrSeen = 0, addrBad = 0, kindBad = 0, wdBad = 0;
  bit prevDone = 0, doubleDone = 0, prevPsen = 0, burstWin = 0;
  int psenFalls = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // driver: computes the expected item, queues it, then presents the request
  task automatic issue(input logic [1:0] kind, input bit useAle, input bit wide,
                       input logic [1:0] tot, input logic [1:0] code,
                       input logic [2:0] hold, input logic [15:0] addr,
                       input logic [15:0] wd, input int forceStr, input string tag);
    item_t it;
    int total;
    @(negedge clk);
    it.kind = kind;
    it.addr = addr;
    it.wd   = wd;
    it.aleH = useAle ? (wide ? 3 : 1) : 0;
    if (useAle) begin
      total   = 2 * (int'(tot) + 2);
      it.strH = total - it.aleH - 1;
      if (it.strH < 1) it.strH = 1;
    end else begin
      it.strH = 2 * (int'(code) + 1);
    end
    if (forceStr > 0) it.strH = forceStr;
    it.setupH = (kind == 2'd2) ? (useAle ? it.aleH + 1 : 1) : 0;
    it.holdH  = (kind == 2'd2) ? int'(hold) : 0;
    it.tag    = tag;
    reqKind = kind; reqUseAle = useAle; reqAddr = addr; reqWrData = wd;
    cfgAleWide = wide; cfgAleTotal = tot; cfgStrobeCode = code; cfgWrHold = hold;
    #1;
    while (!reqReady) @(negedge clk);
    expQ.push_back(it);
    issued++;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor: measures phases and compares against the queue head at done
  always @(negedge clk) begin
    if (rstN) begin
      if (doneOut) begin
        doneCount++;
        if (prevDone) doubleDone = 1;
        if (expQ.size() == 0) begin
          chk(1'b0, "R8", "done with nothing pending", 1, 0);
        end else begin
          head = expQ.pop_front();
          chk(aleCnt == head.aleH, "R1", "latch pulse halves", aleCnt, head.aleH);
          chk(strCnt == head.strH, head.tag, "strobe halves", strCnt, head.strH);
          if (head.kind == 2'd2) begin
            chk(setupCnt == head.setupH, "R6", "data lead halves", setupCnt, head.setupH);
            chk(holdCnt == head.holdH, "R6", "data hold halves", holdCnt, head.holdH);
            chk(!wdBad, "R6", "write data on pins", 1, 0);
          end else begin
            chk(readData == (head.addr ^ MEM_KEY), "R7", "read data",
                readData, head.addr ^ MEM_KEY);
          end
          chk(!addrBad, "R11", "address driven", addrBad, 0);
          chk(!kindBad, "R4", "strobe select", kindBad, 0);
        end
        aleCnt = 0; strCnt = 0; setupCnt = 0; holdCnt = 0;
        wrSeen = 0; addrBad = 0; kindBad = 0; wdBad = 0;
      end
      prevDone = doneOut;
      if (burstWin && prevPsen && !psenOut) psenFalls++;
      prevPsen = psenOut;
      if (expQ.size() != 0) begin
        head = expQ[0];
        if (aleOut) aleCnt++;
        if (psenOut || rdOut || wrOut) begin
          strCnt++;
          if (psenOut != (head.kind == 2'd0) || wrOut != (head.kind == 2'd2) ||
              rdOut != (head.kind == 2'd1 || head.kind == 2'd3)) kindBad = 1;
        end
        if (dataOe && !wrOut && !wrSeen) setupCnt++;
        if (wrOut) begin
          wrSeen = 1;
          if (dataOut != head.wd) wdBad = 1;
        end
        if (dataOe && !wrOut && wrSeen) holdCnt++;
        if ((aleOut || psenOut || rdOut || wrOut || dataOe) &&
            !(addrOe && addrOut == head.addr)) addrBad = 1;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqKind = 2'd0; reqUseAle = 1'b0;
    reqAddr = '0; reqWrData = '0; cfgAleWide = 1'b0; cfgAleTotal = 2'd0;
    cfgStrobeCode = 2'd0; cfgWrHold = 3'd0; waitIn = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!aleOut && !psenOut && !rdOut && !wrOut, "R12", "strobes in reset", 1, 0);
    chk(!addrOe && !dataOe && !doneOut, "R12", "enables in reset", 1, 0);
    chk(reqReady, "R12", "ready in reset", reqReady, 1);
    rstN = 1'b1;

    // R2 reads without latch pulse, every strobe code
    for (int c = 0; c < 4; c++) begin
      issue(2'd1, 0, 0, 2'd0, 2'(c), 3'd0, 16'h1000 + 16'(c), 16'h0, 0, "R2");
    end
    // R9 ready low mid-cycle
    issue(2'd1, 0, 0, 2'd0, 2'd3, 3'd0, 16'h1100, 16'h0, 0, "R2");
    chk(!reqReady, "R9", "ready during read", reqReady, 0);
    drain();
    chk(reqReady, "R9", "ready when idle", reqReady, 1);

    // R2 lone fetch, R4 kind code 3
    issue(2'd0, 0, 0, 2'd0, 2'd2, 3'd0, 16'h2000, 16'h0, 0, "R2");
    issue(2'd3, 0, 0, 2'd0, 2'd1, 3'd0, 16'h2100, 16'h0, 0, "R4");

    // R3 cycles with latch pulse
    issue(2'd1, 1, 0, 2'd0, 2'd0, 3'd0, 16'h3000, 16'h0, 0, "R3");
    issue(2'd1, 1, 1, 2'd0, 2'd0, 3'd0, 16'h3001, 16'h0, 0, "R3");
    chk(!reqReady, "R9", "ready during latch cycle", reqReady, 0);
    issue(2'd1, 1, 1, 2'd2, 2'd0, 3'd0, 16'h3002, 16'h0, 0, "R3");
    issue(2'd1, 1, 0, 2'd3, 2'd0, 3'd0, 16'h3003, 16'h0, 0, "R3");
    issue(2'd0, 1, 1, 2'd1, 2'd0, 3'd0, 16'h3004, 16'h0, 0, "R3");

    // R6 writes
    issue(2'd2, 0, 0, 2'd0, 2'd1, 3'd0, 16'h4000, 16'hBEEF, 0, "R2");
    issue(2'd2, 1, 1, 2'd2, 2'd0, 3'd3, 16'h4001, 16'h1234, 0, "R3");
    issue(2'd2, 0, 0, 2'd0, 2'd0, 3'd7, 16'h4002, 16'h5A5A, 0, "R2");
    drain();

    // R5 wait extension: code 0 gives 2 halves, wait released in the 5th
    waitIn = 1'b1;
    issue(2'd1, 0, 0, 2'd0, 2'd0, 3'd0, 16'h5000, 16'h0, 5, "R5");
    begin
      int n = 0;
      while (n < 5) begin
        if (rdOut) n++;
        if (n < 5) @(negedge clk);
      end
    end
    waitIn = 1'b0;
    drain();

    // R10 burst of three fetches
    burstWin = 1;
    issue(2'd0, 0, 0, 2'd0, 2'd1, 3'd0, 16'h6000, 16'h0, 0, "R10");
    issue(2'd0, 0, 0, 2'd0, 2'd0, 3'd0, 16'h6001, 16'h0, 0, "R10");
    issue(2'd0, 0, 0, 2'd0, 2'd3, 3'd0, 16'h6002, 16'h0, 0, "R10");
    drain();
    burstWin = 0;
    chk(psenFalls == 1, "R10", "fetch strobe falls in burst", psenFalls, 1);

    chk(doneCount == issued, "R8", "done pulses", doneCount, issued);
    chk(!doubleDone, "R8", "done wider than one cycle", doubleDone, 0);
    chk(!addrOe && !dataOe, "R11", "enables idle", addrOe, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule